// File: doc/BRIEF.md
# Sharing-Aware Coherence State Controller

This block keeps coherence state for the lines of a shared last-level cache in a small multicore. Coherence is enforced by where a line may live, not by lists of sharers. A line that only one core touches, or that nobody writes, may be copied into private caches. A line that is both shared and written is pulled back into the shared level and stays there.

Each tracked line has three flags: shared, written, and token. The token flag means one private cache holds the line exclusively. The owning core ID is stored beside the token flag. The private caches send three kinds of event, each with the requester's core ID: read miss, write-through and private eviction. The shared level itself can also reclaim a line.

For each request the controller replies with a grant or deny for a private copy, with the token, and with the line's updated flags. When the line must be pulled back, the controller first broadcasts an invalidation. It gives no reply until every core has acknowledged that broadcast.

Top module: `coh_place_ctrl`

## Requirements
- R1: After reset every line is untracked, with flags {shared,written,token} = 000. `reqReady` is high, and `rspValid` and `invValid` are low.
- R2: A read of a line whose flags are 000 is granted with the token. The flags become 001. `rspValid` is high in the cycle after the request is accepted.
- R3: A private eviction (reqKind 2) from the token holder sets the flags to 000. The same eviction from any other core leaves the flags unchanged. Both are answered with grant 0 and token 0.
- R4: A write-through (reqKind 1) from the token holder that carries the token flag is granted with the token. The flags become 011, and shared stays clear.
- R5: A read of an unwritten line by a core that does not hold the token is granted without the token. The flags become 100. No invalidation is issued, and any number of cores may then read the line this way.
- R6: Once the shared flag is set, no private eviction clears it.
- R7: An access that makes a line both shared and written raises `invValid` with that line on `invLine`. This covers a write by a non-owner, a read by a non-owner of a written line, and a write to a read-only shared line. The reply comes only after every bit of `invAck` has been seen, and the bits may arrive in separate cycles. The reply then gives grant 0 and flags 110.
- R8: Reads and writes to a line with flags 110 are denied with grant 0 and token 0. No invalidation is issued and the flags stay 110.
- R9: A shared-level reclaim (reqKind 3) of a line with any private copy (shared or token flag set) first invalidates, then sets the flags to 000. A reclaim of a line already at 000 is answered at once, without invalidation.
- R10: `reqReady` is low from the cycle after acceptance until the reply cycle has ended, and the token is never returned together with the shared flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqKind | input | 2 | 0 read, 1 write-through, 2 private eviction, 3 shared-level reclaim |
| reqCore | input | $clog2(NUM_CORES) | Requesting core |
| reqLine | input | $clog2(NUM_LINES) | Line index |
| reqHasToken | input | 1 | Writer claims to hold the token |
| reqReady | output | 1 | Controller idle, request accepted this cycle |
| rspValid | output | 1 | Reply cycle |
| rspGrant | output | 1 | Private copy allowed |
| rspToken | output | 1 | Requester holds the exclusive token |
| rspState | output | 3 | Updated flags {shared,written,token} |
| invValid | output | 1 | Invalidation broadcast pending |
| invLine | output | $clog2(NUM_LINES) | Line being invalidated |
| invAck | input | NUM_CORES | Per-core invalidation acknowledge pulses |

## Verification
The main function is driven through whole line lifetimes. These include the private read, write and evict cycle, and sharing reached by a second reader, a foreign writer, or a foreign reader of written data. They also include reclaim of both busy and idle lines. Each of these paths ends in a different flag triple and grant. A sequence that only differs in which core asks separates owner checks from plain state checks. The acknowledge bits are also delivered one at a time, with a repeated bit, to show that the reply waits for the full set and not for a count of pulses.

// File: rtl/coh_place_pkg.sv
package coh_place_pkg;
  typedef enum logic [1:0] {
    REQ_READ    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_DROP    = 2'd2,
    REQ_RECLAIM = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic shared;
    logic written;
    logic token;
  } lineBits_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } tblCtl_t;
endpackage

// File: rtl/coh_place_table.sv
module coh_place_table
  import coh_place_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tblCtl_t           ctl,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              reqHasToken,
  output logic              needInv,
  output logic [LINE_W-1:0] pendLine,
  output logic              pendGrant,
  output logic              pendToken,
  output lineBits_t         pendBits
);
  lineBits_t         bitsQ  [NUM_LINES];
  logic [CORE_W-1:0] ownerQ [NUM_LINES];

  lineBits_t         cur, nxt;
  logic [CORE_W-1:0] curOwner, nxtOwner, pendOwnerQ;
  logic              isOwner, pinned, grant, tok;

  always_comb begin
    cur      = bitsQ[reqLine];
    curOwner = ownerQ[reqLine];
    isOwner  = cur.token && (curOwner == reqCore);
    pinned   = cur.shared && cur.written;
    nxt      = cur;
    nxtOwner = curOwner;
    grant    = 1'b0;
    tok      = 1'b0;
    needInv  = 1'b0;
    unique case (reqKind_e'(reqKind))
      REQ_READ: begin
        if (pinned) begin
          grant = 1'b0;
        end else if (cur.token && !isOwner) begin
          nxt.shared = 1'b1;
          nxt.token  = 1'b0;
          if (cur.written) needInv = 1'b1;
          else             grant   = 1'b1;
        end else if (isOwner) begin
          grant = 1'b1;
          tok   = 1'b1;
        end else if (!cur.shared) begin
          nxt.token = 1'b1;
          nxtOwner  = reqCore;
          grant     = 1'b1;
          tok       = 1'b1;
        end else begin
          grant = 1'b1;
        end
      end
      REQ_WRITE: begin
        if (pinned) begin
          grant = 1'b0;
        end else if (isOwner && reqHasToken) begin
          nxt.written = 1'b1;
          grant       = 1'b1;
          tok         = 1'b1;
        end else if (!cur.token && !cur.shared) begin
          nxt      = '{shared: 1'b0, written: 1'b1, token: 1'b1};
          nxtOwner = reqCore;
          grant    = 1'b1;
          tok      = 1'b1;
        end else begin
          nxt     = '{shared: 1'b1, written: 1'b1, token: 1'b0};
          needInv = 1'b1;
        end
      end
      REQ_DROP: begin
        if (isOwner) nxt = '0;
      end
      default: begin
        nxt     = '0;
        needInv = cur.token || cur.shared;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pendLine   <= '0;
      pendGrant  <= 1'b0;
      pendToken  <= 1'b0;
      pendBits   <= '0;
      pendOwnerQ <= '0;
    end else if (ctl.capture) begin
      pendLine   <= reqLine;
      pendGrant  <= grant;
      pendToken  <= tok;
      pendBits   <= nxt;
      pendOwnerQ <= nxtOwner;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        bitsQ[i]  <= '0;
        ownerQ[i] <= '0;
      end
    end else if (ctl.commit) begin
      bitsQ[pendLine]  <= pendBits;
      ownerQ[pendLine] <= pendOwnerQ;
    end
  end
endmodule

// File: rtl/coh_place_fsm.sv
module coh_place_fsm
  import coh_place_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic                 needInv,
  input  logic [NUM_CORES-1:0] invAck,
  output tblCtl_t              ctl,
  output logic                 reqReady,
  output logic                 rspValid,
  output logic                 invValid
);
  typedef enum logic [1:0] {ST_IDLE, ST_INV, ST_RESP} st_e;
  st_e                  stQ;
  logic [NUM_CORES-1:0] ackSeenQ;
  logic                 accept, allAck;

  assign accept      = reqValid && (stQ == ST_IDLE);
  assign allAck      = &(ackSeenQ | invAck);
  assign ctl.capture = accept;
  assign ctl.commit  = (stQ == ST_RESP);
  assign reqReady    = (stQ == ST_IDLE);
  assign rspValid    = (stQ == ST_RESP);
  assign invValid    = (stQ == ST_INV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stQ      <= ST_IDLE;
      ackSeenQ <= '0;
    end else begin
      unique case (stQ)
        ST_IDLE: begin
          ackSeenQ <= '0;
          if (accept) stQ <= needInv ? ST_INV : ST_RESP;
        end
        ST_INV: begin
          ackSeenQ <= ackSeenQ | invAck;
          if (allAck) stQ <= ST_RESP;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coh_place_ctrl.sv
module coh_place_ctrl
  import coh_place_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  localparam int CORE_W = $clog2(NUM_CORES),
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [1:0]           reqKind,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [LINE_W-1:0]    reqLine,
  input  logic                 reqHasToken,
  output logic                 reqReady,
  output logic                 rspValid,
  output logic                 rspGrant,
  output logic                 rspToken,
  output logic [2:0]           rspState,
  output logic                 invValid,
  output logic [LINE_W-1:0]    invLine,
  input  logic [NUM_CORES-1:0] invAck
);
  tblCtl_t   ctl;
  logic      needInv;
  lineBits_t pendBits;

  coh_place_fsm #(.NUM_CORES(NUM_CORES)) uFsm (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .needInv(needInv),
    .invAck(invAck), .ctl(ctl), .reqReady(reqReady), .rspValid(rspValid),
    .invValid(invValid)
  );

  coh_place_table #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) uTbl (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .reqKind(reqKind), .reqCore(reqCore),
    .reqLine(reqLine), .reqHasToken(reqHasToken), .needInv(needInv),
    .pendLine(invLine), .pendGrant(rspGrant), .pendToken(rspToken),
    .pendBits(pendBits)
  );

  assign rspState = pendBits;
endmodule

// File: rtl/coh_place_chk.sv
module coh_place_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 16,
  localparam int LINE_W = $clog2(NUM_LINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspGrant,
  input logic              rspToken,
  input logic [2:0]        rspState,
  input logic              invValid,
  input logic [LINE_W-1:0] invLine
);
  assert_token_private_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && rspToken |-> rspState[0] && !rspState[2]);

  assert_no_token_when_shared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && rspState[2] |-> !rspState[0] && !rspToken);

  assert_pinned_denied_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid && rspState[2] && rspState[1] |-> !rspGrant);

  assert_inv_then_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(invValid) |-> rspValid);

  assert_inv_line_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    invValid && $past(invValid) |-> $stable(invLine));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);

  assert_reply_excl_inv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(invValid && rspValid));
endmodule

bind coh_place_ctrl coh_place_chk #(.NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) uChk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspGrant(rspGrant), .rspToken(rspToken),
  .rspState(rspState), .invValid(invValid), .invLine(invLine)
);

// File: tb/sim_coh_place_ctrl.sv
module sim_coh_place_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqKind = '0;
  logic [1:0] reqCore = '0;
  logic [3:0] reqLine = '0;
  logic       reqHasToken = 1'b0;
  logic       reqReady, rspValid, rspGrant, rspToken, invValid;
  logic [2:0] rspState;
  logic [3:0] invLine;
  logic [3:0] invAck = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  coh_place_ctrl #(.NUM_CORES(4), .NUM_LINES(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqKind(reqKind),
    .reqCore(reqCore), .reqLine(reqLine), .reqHasToken(reqHasToken),
    .reqReady(reqReady), .rspValid(rspValid), .rspGrant(rspGrant),
    .rspToken(rspToken), .rspState(rspState), .invValid(invValid),
    .invLine(invLine), .invAck(invAck)
  );

  // kind[14:13] core[12:11] line[10:7] tok[6] grant[5] token[4] state[3:1] inv[0]
  localparam int NV = 19;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'd3, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0},  // R2 first read
    {2'd1, 2'd0, 4'd3, 1'b1, 1'b1, 1'b1, 3'b011, 1'b0},  // R4 owner write
    {2'd2, 2'd0, 4'd3, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0},  // R3 owner evict
    {2'd0, 2'd1, 4'd3, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0},  // R2 read again
    {2'd2, 2'd2, 4'd3, 1'b0, 1'b0, 1'b0, 3'b001, 1'b0},  // R3 non-owner evict
    {2'd0, 2'd2, 4'd3, 1'b0, 1'b1, 1'b0, 3'b100, 1'b0},  // R5 second reader
    {2'd0, 2'd3, 4'd3, 1'b0, 1'b1, 1'b0, 3'b100, 1'b0},  // R5 third reader
    {2'd2, 2'd1, 4'd3, 1'b0, 1'b0, 1'b0, 3'b100, 1'b0},  // R6 sticky shared
    {2'd1, 2'd2, 4'd3, 1'b0, 1'b0, 1'b0, 3'b110, 1'b1},  // R7 write to read-only shared
    {2'd0, 2'd0, 4'd3, 1'b0, 1'b0, 1'b0, 3'b110, 1'b0},  // R8 read pinned
    {2'd1, 2'd1, 4'd3, 1'b0, 1'b0, 1'b0, 3'b110, 1'b0},  // R8 write pinned
    {2'd3, 2'd0, 4'd3, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1},  // R9 reclaim busy
    {2'd3, 2'd0, 4'd5, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0},  // R9 reclaim idle
    {2'd0, 2'd1, 4'd5, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0},  // R2
    {2'd1, 2'd3, 4'd5, 1'b0, 1'b0, 1'b0, 3'b110, 1'b1},  // R7 foreign write
    {2'd0, 2'd0, 4'd7, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0},  // R2
    {2'd1, 2'd0, 4'd7, 1'b1, 1'b1, 1'b1, 3'b011, 1'b0},  // R4
    {2'd0, 2'd2, 4'd7, 1'b0, 1'b0, 1'b0, 3'b110, 1'b1},  // R7 foreign read of written
    {2'd1, 2'd1, 4'd9, 1'b0, 1'b1, 1'b1, 3'b011, 1'b0}   // R4 first write
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic doReq(input logic [14:0] v, input string tag);
    @(negedge clk);
    reqValid = 1'b1; reqKind = v[14:13]; reqCore = v[12:11];
    reqLine = v[10:7]; reqHasToken = v[6];
    @(negedge clk);
    reqValid = 1'b0;
    check(invValid == v[0], {tag, " invValid"}, int'(invValid), int'(v[0]));
    if (invValid) begin
      check(invLine == v[10:7], {tag, " invLine"}, int'(invLine), int'(v[10:7]));
      invAck = 4'hF;
      @(negedge clk);
      invAck = 4'h0;
    end
    check(rspValid == 1'b1, {tag, " rspValid"}, int'(rspValid), 1);
    check(rspGrant == v[5], {tag, " grant"}, int'(rspGrant), int'(v[5]));
    check(rspToken == v[4], {tag, " token"}, int'(rspToken), int'(v[4]));
    check(rspState == v[3:1], {tag, " state"}, int'(rspState), int'(v[3:1]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1'b1, "R1 ready", int'(reqReady), 1);
    check(rspValid == 1'b0, "R1 rspValid", int'(rspValid), 0);
    check(invValid == 1'b0, "R1 invValid", int'(invValid), 0);
    doReq({2'd0, 2'd2, 4'd15, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0}, "R1 untracked after reset");

    for (int i = 0; i < NV; i++) doReq(VEC[i], $sformatf("vec%0d", i));

    // R7 staggered acknowledges with a repeated bit
    doReq({2'd0, 2'd0, 4'd11, 1'b0, 1'b1, 1'b1, 3'b001, 1'b0}, "R2 setup");
    doReq({2'd0, 2'd1, 4'd11, 1'b0, 1'b1, 1'b0, 3'b100, 1'b0}, "R5 setup");
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'd1; reqCore = 2'd0; reqLine = 4'd11; reqHasToken = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R10 busy", int'(reqReady), 0);
    invAck = 4'b0001; @(negedge clk);
    invAck = 4'b0010; @(negedge clk);
    invAck = 4'b0001; @(negedge clk);
    invAck = 4'b0100; @(negedge clk);
    invAck = 4'b0000;
    check(rspValid == 1'b0, "R7 waits for all acks", int'(rspValid), 0);
    check(invValid == 1'b1, "R7 inv held", int'(invValid), 1);
    check(reqReady == 1'b0, "R10 busy during inv", int'(reqReady), 0);
    invAck = 4'b1000; @(negedge clk);
    invAck = 4'b0000;
    check(rspValid == 1'b1, "R7 reply after last ack", int'(rspValid), 1);
    check(rspState == 3'b110, "R7 state", int'(rspState), 6);
    check(rspGrant == 1'b0, "R7 grant", int'(rspGrant), 0);
    @(negedge clk);
    check(reqReady == 1'b1, "R10 ready after reply", int'(reqReady), 1);
    check(rspValid == 1'b0, "R10 single reply", int'(rspValid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule